// File: doc/BRIEF.md
# Chainable Down-Counter Timer Bank with Watchdog

This block holds several identical down-counting timers behind a small word-addressed register port. Each timer decrements once per cycle in which the shared `tick_i` enable is high. A timer can instead be set to follow its lower-numbered neighbour, so that it decrements only on that neighbour's underflow. This makes one wide counter out of two or more. Each timer has a reload value, a control word, a latch snapshot and a sticky interrupt flag.

The highest-numbered timer is the watchdog. Its reset defaults differ from the others: it reloads from 0xFFFF, it starts enabled unless the board strap inputs say otherwise, and its interrupt can drive a watchdog output and a non-maskable interrupt line. A debug-freeze input stops every counter. A latch strobe snapshots all counters at once.

Register map: each timer owns four words, and the word address is `{timer_index, reg}`. The values of `reg` are: 0 = counter, 1 = reload, 2 = control, 3 = latch (read-only).

The control word bits are: 0 enable, 1 restart, 2 load, 3 interrupt enable, 4 pending (write 1 to clear), 5 follow-neighbour, 6 freeze state (read-only), 7 NMI enable (watchdog only), 8 watchdog-output disable (watchdog only). All other bits read as zero.

Top module: `tmr_bank`

## Requirements
- R1: Writing control with bit 2 set makes the counter equal the reload value one cycle after the write, after which bit 2 reads 0.
- R2: A decrement event on a counter at zero is an underflow. With restart (bit 1) set, the counter then takes the reload value.
- R3: On underflow with restart clear, the counter wraps to all ones.
- R4: With bit 5 set, timer n (n>0) decrements only on an underflow of timer n-1 and ignores `tick_i`.
- R5: An underflow sets pending (bit 4, and `irq_o[n]`) only if interrupt enable (bit 3) is 1.
- R6: Writing control with bit 4 = 1 clears pending. Writing bit 4 = 0 leaves it unchanged.
- R7: After reset the watchdog has reload 0x0000FFFF, interrupt enable 1, restart 0, follow 0, and its counter loads 0xFFFF. The other timers reset with control reading 0.
- R8: The watchdog starts enabled after reset only if `brk_n_i` is high and `dbg_en_i` is low.
- R9: `wdog_o` is high while the watchdog is pending and bit 8 is 0. `nmi_o` is high while the watchdog is pending and bit 7 is 1.
- R10: While `freeze_i` is high no counter changes on a tick, and control bit 6 reads 1.
- R11: A `latch_i` pulse copies every counter into its latch register, which holds until the next pulse.
- R12: On a non-watchdog timer, control bits 7, 8 and all bits above 8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_n_i | input | 1 | Strap; low keeps the watchdog disabled after reset |
| dbg_en_i | input | 1 | Strap; high keeps the watchdog disabled after reset |
| tick_i | input | 1 | Prescaled decrement enable |
| freeze_i | input | 1 | Debug freeze for all counters |
| latch_i | input | 1 | Snapshot strobe for all latch registers |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | AW-2 | Word address {timer, reg} |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for reg_addr_i |
| irq_o | output | N_TMR | Per-timer pending flags |
| nmi_o | output | 1 | Watchdog non-maskable interrupt |
| wdog_o | output | 1 | Watchdog output |

## Verification
The hardest case to reach is an underflow in a follower timer. It needs the neighbour to be reloading in restart mode at a known phase while the follower holds a known count. The bench writes the follower's counter directly and gives the neighbour a reload of 1, so one underflow arrives every two ticks. It then checks that the follower does not move on the tick in between. The watchdog timeout is brought about in a similar way: writing its counter to 1 avoids 65536 ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Field positions inside the control word.
    localparam int unsigned CB_EN = 0;
    localparam int unsigned CB_RS = 1;
    localparam int unsigned CB_LD = 2;
    localparam int unsigned CB_IE = 3;
    localparam int unsigned CB_IP = 4;
    localparam int unsigned CB_CH = 5;
    localparam int unsigned CB_FZ = 6;
    localparam int unsigned CB_WN = 7;
    localparam int unsigned CB_WS = 8;

    // Register select inside a timer's four words.
    localparam logic [1:0] RG_CNT = 2'd0;
    localparam logic [1:0] RG_RLD = 2'd1;
    localparam logic [1:0] RG_CTL = 2'd2;
    localparam logic [1:0] RG_LAT = 2'd3;

    typedef struct packed {
        logic ws;   // watchdog output disable
        logic wn;   // nmi enable
        logic ch;   // follow neighbour
        logic ip;   // pending
        logic ie;   // interrupt enable
        logic ld;   // load request
        logic rs;   // restart
        logic en;   // enable
    } tmr_ctl_t;

endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int   CNT_W = 32,
    parameter bit   IS_WD = 1'b0,
    parameter int   WD_RLD = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en_rst_i,
    input  logic             tick_i,
    input  logic             prev_uf_i,
    input  logic             freeze_i,
    input  logic             latch_i,
    input  logic             cnt_we_i,
    input  logic             rld_we_i,
    input  logic             ctl_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CNT_W-1:0] lat_o,
    output tmr_ctl_t         ctl_o,
    output logic             uf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] lat;
        tmr_ctl_t         ctl;
    } st_t;

    st_t  s_d, s_q;
    logic dec_d;
    logic uf_d;

    always_comb begin
        s_d   = s_q;
        dec_d = s_q.ctl.en & ~freeze_i & (s_q.ctl.ch ? prev_uf_i : tick_i);
        uf_d  = dec_d & (s_q.cnt == '0) & ~s_q.ctl.ld & ~cnt_we_i;

        if (s_q.ctl.ld) begin
            s_d.cnt    = s_q.rld;
            s_d.ctl.ld = 1'b0;
        end else if (dec_d) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = s_q.ctl.rs ? s_q.rld : '1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (cnt_we_i) s_d.cnt = wdata_i;
        if (rld_we_i) s_d.rld = wdata_i;

        if (ctl_we_i) begin
            s_d.ctl.en = wdata_i[CB_EN];
            s_d.ctl.rs = wdata_i[CB_RS];
            s_d.ctl.ld = wdata_i[CB_LD];
            s_d.ctl.ie = wdata_i[CB_IE];
            s_d.ctl.ch = wdata_i[CB_CH];
            if (wdata_i[CB_IP]) s_d.ctl.ip = 1'b0;
            s_d.ctl.wn = IS_WD ? wdata_i[CB_WN] : 1'b0;
            s_d.ctl.ws = IS_WD ? wdata_i[CB_WS] : 1'b0;
        end

        if (uf_d && s_q.ctl.ie) s_d.ctl.ip = 1'b1;

        if (latch_i) s_d.lat = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            if (IS_WD) begin
                s_q.rld    <= CNT_W'(WD_RLD);
                s_q.ctl.ie <= 1'b1;
                s_q.ctl.ld <= 1'b1;
                s_q.ctl.en <= wd_en_rst_i;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign rld_o = s_q.rld;
    assign lat_o = s_q.lat;
    assign ctl_o = s_q.ctl;
    assign uf_o  = uf_d;

endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int CNT_W = 32,
    parameter int IDX_W = 2
) (
    input  logic                        we_i,
    input  logic [IDX_W+1:0]            addr_i,
    input  logic                        freeze_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] cnt_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] rld_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] lat_i,
    input  tmr_ctl_t [N_TMR-1:0]        ctl_i,
    output logic [N_TMR-1:0]            cnt_we_o,
    output logic [N_TMR-1:0]            rld_we_o,
    output logic [N_TMR-1:0]            ctl_we_o,
    output logic [CNT_W-1:0]            rdata_o
);

    logic [IDX_W-1:0] idx;
    logic [1:0]       rg;
    logic             hit;

    assign idx = addr_i[IDX_W+1:2];
    assign rg  = addr_i[1:0];
    assign hit = (int'(idx) < N_TMR);

    always_comb begin
        cnt_we_o = '0;
        rld_we_o = '0;
        ctl_we_o = '0;
        rdata_o  = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (hit && (int'(idx) == i)) begin
                cnt_we_o[i] = we_i && (rg == RG_CNT);
                rld_we_o[i] = we_i && (rg == RG_RLD);
                ctl_we_o[i] = we_i && (rg == RG_CTL);
                unique case (rg)
                    RG_CNT: rdata_o = cnt_i[i];
                    RG_RLD: rdata_o = rld_i[i];
                    RG_LAT: rdata_o = lat_i[i];
                    default: begin
                        rdata_o[CB_EN] = ctl_i[i].en;
                        rdata_o[CB_RS] = ctl_i[i].rs;
                        rdata_o[CB_LD] = ctl_i[i].ld;
                        rdata_o[CB_IE] = ctl_i[i].ie;
                        rdata_o[CB_IP] = ctl_i[i].ip;
                        rdata_o[CB_CH] = ctl_i[i].ch;
                        rdata_o[CB_FZ] = freeze_i;
                        rdata_o[CB_WN] = ctl_i[i].wn;
                        rdata_o[CB_WS] = ctl_i[i].ws;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int  N_TMR = 4,
    parameter int  CNT_W = 32,
    localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int AW    = IDX_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_n_i,
    input  logic             dbg_en_i,
    input  logic             tick_i,
    input  logic             freeze_i,
    input  logic             latch_i,
    input  logic             reg_we_i,
    input  logic [AW-3:0]    reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic [N_TMR-1:0] irq_o,
    output logic             nmi_o,
    output logic             wdog_o
);

    localparam int LAST = N_TMR - 1;

    logic [N_TMR-1:0][CNT_W-1:0] cnt_a, rld_a, lat_a;
    tmr_ctl_t [N_TMR-1:0]        ctl_a;
    logic [N_TMR-1:0]            uf_a;
    logic [N_TMR-1:0]            cnt_we_a, rld_we_a, ctl_we_a;
    logic                        wd_en_rst;

    assign wd_en_rst = brk_n_i & ~dbg_en_i;

    tmr_regdec #(
        .N_TMR (N_TMR),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_dec (
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .freeze_i (freeze_i),
        .cnt_i    (cnt_a),
        .rld_i    (rld_a),
        .lat_i    (lat_a),
        .ctl_i    (ctl_a),
        .cnt_we_o (cnt_we_a),
        .rld_we_o (rld_we_a),
        .ctl_we_o (ctl_we_a),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic prev_uf;
        if (g == 0) begin : g_first
            assign prev_uf = 1'b0;
        end else begin : g_next
            assign prev_uf = uf_a[g-1];
        end

        tmr_unit #(
            .CNT_W (CNT_W),
            .IS_WD (g == LAST)
        ) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .wd_en_rst_i (wd_en_rst),
            .tick_i      (tick_i),
            .prev_uf_i   (prev_uf),
            .freeze_i    (freeze_i),
            .latch_i     (latch_i),
            .cnt_we_i    (cnt_we_a[g]),
            .rld_we_i    (rld_we_a[g]),
            .ctl_we_i    (ctl_we_a[g]),
            .wdata_i     (reg_wdata_i),
            .cnt_o       (cnt_a[g]),
            .rld_o       (rld_a[g]),
            .lat_o       (lat_a[g]),
            .ctl_o       (ctl_a[g]),
            .uf_o        (uf_a[g])
        );

        assign irq_o[g] = ctl_a[g].ip;
    end

    assign wdog_o = ctl_a[LAST].ip & ~ctl_a[LAST].ws;
    assign nmi_o  = ctl_a[LAST].ip &  ctl_a[LAST].wn;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int CNT_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        freeze_i,
    input logic [N_TMR-1:0][CNT_W-1:0] cnt_a,
    input logic [N_TMR-1:0][CNT_W-1:0] rld_a,
    input tmr_ctl_t [N_TMR-1:0]        ctl_a,
    input logic [N_TMR-1:0]            uf_a,
    input logic [N_TMR-1:0]            cnt_we_a,
    input logic [N_TMR-1:0]            ctl_we_a,
    input logic [N_TMR-1:0]            irq_o,
    input logic                        nmi_o,
    input logic                        wdog_o
);

    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        p_load_copies_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_a[i].ld && !cnt_we_a[i] && !ctl_we_a[i])
            |=> (cnt_a[i] == $past(rld_a[i])) && !ctl_a[i].ld);

        p_restart_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_a[i] && ctl_a[i].rs) |=> (cnt_a[i] == $past(rld_a[i])));

        p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_a[i] && !ctl_a[i].rs) |=> (cnt_a[i] == '1));

        p_pend_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_a[i].ip) |-> $past(uf_a[i] && ctl_a[i].ie));

        p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze_i && !cnt_we_a[i] && !ctl_a[i].ld) |=> $stable(cnt_a[i]));

        if (i > 0) begin : g_follow
            p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_a[i].ch && !uf_a[i-1] && !cnt_we_a[i] && !ctl_a[i].ld)
                |=> $stable(cnt_a[i]));
        end
    end

    p_nmi_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> irq_o[N_TMR-1]);

    p_wdog_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_o |-> irq_o[N_TMR-1]);

endmodule

bind tmr_bank tmr_bank_chk #(
    .N_TMR (N_TMR),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze_i),
    .cnt_a    (cnt_a),
    .rld_a    (rld_a),
    .ctl_a    (ctl_a),
    .uf_a     (uf_a),
    .cnt_we_a (cnt_we_a),
    .ctl_we_a (ctl_we_a),
    .irq_o    (irq_o),
    .nmi_o    (nmi_o),
    .wdog_o   (wdog_o)
);

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;

    localparam int N  = 4;
    localparam int W  = 32;
    localparam int WD = N - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         brk_n = 1'b1, dbg_en = 1'b0;
    logic         tick = 1'b0, freeze = 1'b0, latch = 1'b0;
    logic         we = 1'b0;
    logic [3:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [N-1:0] irq;
    logic         nmi, wdog;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tmr_bank #(.N_TMR(N), .CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .brk_n_i(brk_n), .dbg_en_i(dbg_en),
        .tick_i(tick), .freeze_i(freeze), .latch_i(latch),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .nmi_o(nmi), .wdog_o(wdog)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int t, input int r, input logic [W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = 4'(t * 4 + r); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int t, input int r, output logic [W-1:0] d);
        @(negedge clk);
        addr = 4'(t * 4 + r);
        #0.5;
        d = rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset(input logic b, input logic d);
        @(negedge clk);
        rst_n = 1'b0; brk_n = b; dbg_en = d;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(WD, 2, v); chk("R7 wd ctrl", v, 32'h9);
        rd(WD, 1, v); chk("R7 wd reload", v, 32'hFFFF);
        rd(WD, 0, v); chk("R7 wd counter", v, 32'hFFFF);
        rd(0, 2, v);  chk("R7 t0 ctrl", v, 32'h0);
        chk("R7 irq idle", W'(irq), '0);
    endtask

    task automatic t_load_restart();
        logic [W-1:0] v;
        wr(0, 1, 32'd3);
        wr(0, 2, 32'h0F);
        @(negedge clk);
        rd(0, 0, v); chk("R1 loaded", v, 32'd3);
        rd(0, 2, v); chk("R1 ld clear", v, 32'h0B);
        repeat (3) pulse_tick();
        rd(0, 0, v); chk("R2 at zero", v, 32'd0);
        chk("R5 no pend yet", W'(irq[0]), '0);
        pulse_tick();
        rd(0, 0, v); chk("R2 reloaded", v, 32'd3);
        rd(0, 2, v); chk("R5 pend bit", v, 32'h1B);
        chk("R5 irq0", W'(irq[0]), 32'd1);
    endtask

    task automatic t_clear();
        logic [W-1:0] v;
        wr(0, 2, 32'h0B);
        rd(0, 2, v); chk("R6 write0 keeps", v, 32'h1B);
        wr(0, 2, 32'h1B);
        rd(0, 2, v); chk("R6 write1 clears", v, 32'h0B);
        chk("R6 irq0 low", W'(irq[0]), '0);
    endtask

    task automatic t_wrap();
        logic [W-1:0] v;
        wr(0, 2, 32'h01);
        wr(0, 0, 32'd0);
        pulse_tick();
        rd(0, 0, v); chk("R3 wrap", v, 32'hFFFF_FFFF);
        chk("R5 ie off no pend", W'(irq[0]), '0);
    endtask

    task automatic t_chain();
        logic [W-1:0] v;
        wr(0, 1, 32'd1);
        wr(0, 2, 32'h07);
        wr(1, 0, 32'd2);
        wr(1, 2, 32'h21);
        @(negedge clk);
        pulse_tick();
        rd(1, 0, v); chk("R4 follower ignores tick", v, 32'd2);
        pulse_tick();
        rd(1, 0, v); chk("R4 follower steps", v, 32'd1);
        rd(0, 0, v); chk("R4 leader reloaded", v, 32'd1);
    endtask

    task automatic t_freeze();
        logic [W-1:0] v0, v;
        @(negedge clk); freeze = 1'b1;
        rd(0, 0, v0);
        repeat (3) pulse_tick();
        rd(0, 0, v); chk("R10 frozen", v, v0);
        rd(0, 2, v); chk("R10 fz bit", v & 32'h40, 32'h40);
        @(negedge clk); freeze = 1'b0;
    endtask

    task automatic t_latch();
        logic [W-1:0] c, v;
        rd(0, 0, c);
        @(negedge clk); latch = 1'b1;
        @(negedge clk); latch = 1'b0;
        rd(0, 3, v); chk("R11 snapshot", v, c);
        pulse_tick();
        rd(0, 3, v); chk("R11 holds", v, c);
    endtask

    task automatic t_hidden_bits();
        logic [W-1:0] v;
        wr(1, 2, 32'hFFFF_FF80);
        rd(1, 2, v); chk("R12 upper bits zero", v, 32'h0);
    endtask

    task automatic t_watchdog();
        logic [W-1:0] v;
        wr(WD, 0, 32'd1);
        pulse_tick();
        pulse_tick();
        rd(WD, 0, v); chk("R3 wd wrap", v, 32'hFFFF_FFFF);
        chk("R9 wdog on", W'(wdog), 32'd1);
        chk("R9 nmi off", W'(nmi), 32'd0);
        wr(WD, 2, 32'h89);
        chk("R9 nmi on", W'(nmi), 32'd1);
        wr(WD, 2, 32'h189);
        chk("R9 wdog masked", W'(wdog), 32'd0);
        chk("R9 irq wd kept", W'(irq[WD]), 32'd1);
    endtask

    task automatic t_straps();
        logic [W-1:0] v;
        do_reset(1'b0, 1'b0);
        rd(WD, 2, v); chk("R8 brk low disables", v, 32'h8);
        do_reset(1'b1, 1'b1);
        rd(WD, 2, v); chk("R8 dbg high disables", v, 32'h8);
        do_reset(1'b1, 1'b0);
        rd(WD, 2, v); chk("R8 enabled", v, 32'h9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_load_restart();
        t_clear();
        t_wrap();
        t_chain();
        t_freeze();
        t_latch();
        t_hidden_bits();
        t_watchdog();
        t_straps();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule